// File: doc/BRIEF.md
# Condition Code Register Unit

This block keeps the 8-bit status register of a small processor core. Each cycle it takes the ALU result byte, the carry out of bit 3 and a 3-bit instruction-class code. From these it updates the sign flag and the half-carry flag. It also maintains two interrupt masks: one for the maskable request line and one for the non-maskable pin. Reset, software mask commands, an interrupt-entry strobe from the sequencer and a full reload on return-from-interrupt all change those masks.

The sequencer pulses `int_enter_i` once stacking has finished and before the vector fetch starts. On return-from-interrupt it presents the stacked byte on `rti_val_i` together with `rti_load_i`. Register layout: bit 7 is the pin mask X, bit 6 is the maskable mask I, bit 5 is the half-carry H, bit 4 is the sign flag N, and bits 3..0 are general bits that only the reload writes. The reset is asynchronous and active low. Its release passes through a synchronizer, so the register leaves reset on the second rising clock edge after `rst_ni` goes high. Every other update appears on `ccr_o` one clock after its inputs are sampled.

Top module: `ccr_unit`

## Requirements
- R1: For instruction classes 1 (subtract), 2 (logic) and 3 (move), and for the add classes 4, 5 and 6, bit 4 (N) takes the most significant bit of `alu_res_i` on the next clock.
- R2: For the add classes 4 (add), 5 (accumulator add) and 6 (add with carry), bit 5 (H) takes `half_cy_i` on the next clock.
- R3: While reset is active, and until the synchronized release, `ccr_o` reads 8'hC0 (X and I set, all other bits 0), and every input is ignored.
- R4: `sw_cli_i` clears I and `sw_sei_i` sets I. When both are high in the same cycle, set wins.
- R5: An `int_enter_i` pulse with `int_src_x_i` low sets I and leaves X unchanged.
- R6: An `int_enter_i` pulse with `int_src_x_i` high sets both X and I.
- R7: `rti_load_i` loads bits 6..0 from `rti_val_i`. Bit 7 becomes the AND of the current X and `rti_val_i[7]`.
- R8: `sw_clx_i` clears X. `sw_setx_i` has no effect, and neither does a reload. X rises only through reset or R6.
- R9: Classes 0 (none), 1, 2, 3 and 7 (reserved) leave H unchanged. Classes 0 and 7 also leave N unchanged.
- R10: When `rti_load_i` is high, it overrides the ALU flags, the software commands and interrupt entry in the same cycle.
- R11: `x_mask_o` and `i_mask_o` always equal bits 7 and 6 of `ccr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alu_res_i | input | DATA_W | ALU result |
| half_cy_i | input | 1 | Carry out of bit 3 |
| op_class_i | input | 3 | Instruction class code |
| sw_sei_i | input | 1 | Software set-I command |
| sw_cli_i | input | 1 | Software clear-I command |
| sw_clx_i | input | 1 | Software clear-X command |
| sw_setx_i | input | 1 | Software set-X attempt (ignored) |
| int_enter_i | input | 1 | Interrupt entry strobe |
| int_src_x_i | input | 1 | Entry comes from the non-maskable pin |
| rti_load_i | input | 1 | Return-from-interrupt reload |
| rti_val_i | input | 8 | Stacked register value |
| ccr_o | output | 8 | Register value |
| i_mask_o | output | 1 | Maskable interrupt mask |
| x_mask_o | output | 1 | Pin interrupt mask |

## Verification
The bench uses the defaults: DATA_W of 8 and a two-stage reset synchronizer. With these, the sign bit is bit 7 of the result byte. The two-cycle release window is also short enough that the bench can drive mask commands into it and see them dropped. A vector walk moves the register through each class code, each mask command, both entry sources and reloads with X high and with X low. Directed steps then assert reset in the middle of a run and probe the release window.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_W = 8;
  localparam int BIT_X = 7;
  localparam int BIT_I = 6;
  localparam int BIT_H = 5;
  localparam int BIT_N = 4;
  localparam int GEN_W = 4;
  localparam logic [CCR_W-1:0] CCR_RST  = CCR_W'((1 << BIT_X) | (1 << BIT_I));
  localparam logic [CCR_W-1:0] X_ONLY   = CCR_W'(1 << BIT_X);

  typedef enum logic [2:0] {
    OPC_NONE   = 3'd0,
    OPC_SUB    = 3'd1,
    OPC_LOGIC  = 3'd2,
    OPC_MOVE   = 3'd3,
    OPC_ADD    = 3'd4,
    OPC_ACCADD = 3'd5,
    OPC_ADC    = 3'd6,
    OPC_RSVD   = 3'd7
  } op_class_e;
endpackage

// File: rtl/ccr_rst_sync.sv
module ccr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ccr_arith_flags.sv
module ccr_arith_flags
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op_class_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              half_cy_i,
  input  logic              n_q_i,
  input  logic              h_q_i,
  output logic              n_d_o,
  output logic              h_d_o,
  output logic              upd_o
);
  localparam int MSB = DATA_W - 1;
  op_class_e cls;

  always_comb begin
    cls   = op_class_e'(op_class_i);
    n_d_o = n_q_i;
    h_d_o = h_q_i;
    upd_o = 1'b0;
    case (cls)
      OPC_SUB, OPC_LOGIC, OPC_MOVE: begin
        n_d_o = alu_res_i[MSB];
        upd_o = 1'b1;
      end
      OPC_ADD, OPC_ACCADD, OPC_ADC: begin
        n_d_o = alu_res_i[MSB];
        h_d_o = half_cy_i;
        upd_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ccr_mask_ctrl.sv
module ccr_mask_ctrl (
  input  logic sei_i,
  input  logic cli_i,
  input  logic clx_i,
  input  logic enter_i,
  input  logic src_x_i,
  input  logic i_q_i,
  input  logic x_q_i,
  output logic i_d_o,
  output logic x_d_o,
  output logic upd_o
);
  always_comb begin
    i_d_o = i_q_i;
    if (enter_i)    i_d_o = 1'b1;
    else if (sei_i) i_d_o = 1'b1;
    else if (cli_i) i_d_o = 1'b0;

    x_d_o = x_q_i;
    if (enter_i && src_x_i) x_d_o = 1'b1;
    else if (clx_i)         x_d_o = 1'b0;

    upd_o = enter_i | sei_i | cli_i | clx_i;
  end
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              half_cy_i,
  input  logic [2:0]        op_class_i,
  input  logic              sw_sei_i,
  input  logic              sw_cli_i,
  input  logic              sw_clx_i,
  input  logic              sw_setx_i,
  input  logic              int_enter_i,
  input  logic              int_src_x_i,
  input  logic              rti_load_i,
  input  logic [CCR_W-1:0]  rti_val_i,
  output logic [CCR_W-1:0]  ccr_o,
  output logic              i_mask_o,
  output logic              x_mask_o
);
  logic             srst_n;
  logic [CCR_W-1:0] ccr_q;
  logic [CCR_W-1:0] ccr_d;
  logic             n_d, h_d, i_d, x_d;
  logic             arith_upd, mask_upd, reg_en;
  logic [GEN_W-1:0] gen_d;

  ccr_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_no (srst_n)
  );

  ccr_arith_flags #(.DATA_W(DATA_W)) u_arith (
    .op_class_i (op_class_i),
    .alu_res_i  (alu_res_i),
    .half_cy_i  (half_cy_i),
    .n_q_i      (ccr_q[BIT_N]),
    .h_q_i      (ccr_q[BIT_H]),
    .n_d_o      (n_d),
    .h_d_o      (h_d),
    .upd_o      (arith_upd)
  );

  ccr_mask_ctrl u_mask (
    .sei_i   (sw_sei_i),
    .cli_i   (sw_cli_i),
    .clx_i   (sw_clx_i),
    .enter_i (int_enter_i),
    .src_x_i (int_src_x_i),
    .i_q_i   (ccr_q[BIT_I]),
    .x_q_i   (ccr_q[BIT_X]),
    .i_d_o   (i_d),
    .x_d_o   (x_d),
    .upd_o   (mask_upd)
  );

  for (genvar g = 0; g < GEN_W; g++) begin : g_gen_bits
    always_comb begin
      gen_d[g] = rti_load_i ? rti_val_i[g] : ccr_q[g];
    end
  end

  always_comb begin
    reg_en = rti_load_i | arith_upd | mask_upd;
    if (rti_load_i) begin
      ccr_d        = rti_val_i;
      ccr_d[BIT_X] = ccr_q[BIT_X] & rti_val_i[BIT_X];
    end else begin
      ccr_d          = ccr_q;
      ccr_d[BIT_X]   = x_d;
      ccr_d[BIT_I]   = i_d;
      ccr_d[BIT_H]   = h_d;
      ccr_d[BIT_N]   = n_d;
    end
    ccr_d[GEN_W-1:0] = gen_d;
  end

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n)     ccr_q <= CCR_RST;
    else if (reg_en) ccr_q <= ccr_d;
  end

  assign ccr_o    = ccr_q;
  assign i_mask_o = ccr_q[BIT_I];
  assign x_mask_o = ccr_q[BIT_X];

  AST_RST_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_n |=> (ccr_o == CCR_RST)); // R3
  AST_N_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_n && !rti_load_i && arith_upd |=> ccr_o[BIT_N] == $past(alu_res_i[DATA_W-1])); // R1
  AST_H_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_n && !rti_load_i && !(op_class_i inside {OPC_ADD, OPC_ACCADD, OPC_ADC})
    |=> $stable(ccr_o[BIT_H])); // R9
  AST_I_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_n && int_enter_i && !rti_load_i |=> i_mask_o); // R5
  AST_X_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_n && int_enter_i && int_src_x_i && !rti_load_i |=> x_mask_o && i_mask_o); // R6
  AST_X_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_n && !x_mask_o && !(int_enter_i && int_src_x_i && !rti_load_i) |=> !x_mask_o); // R8
  AST_SETX_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_n && sw_setx_i && !x_mask_o && !int_enter_i |=> !x_mask_o); // R8
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_n && rti_load_i |=> (ccr_o & ~X_ONLY) == ($past(rti_val_i) & ~X_ONLY)); // R10
  AST_MASK_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_mask_o == ccr_o[BIT_X]) && (i_mask_o == ccr_o[BIT_I])); // R11
endmodule

// File: tb/ccr_unit_bench.sv
module ccr_unit_bench;
  typedef struct packed {
    logic [2:0] op;
    logic [7:0] res;
    logic       hc, sei, cli, clx, sxr, ent, src, ld;
    logic [7:0] val;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 23;
  // op, res, hc, sei, cli, clx, sxr, ent, src, ld, val, expected ccr
  localparam vec_t TBL [NV] = '{
    '{3'd4, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hF0}, // R1 R2
    '{3'd2, 8'h05, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hE0}, // R1 R9
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA0}, // R4
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h20}, // R8
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h20}, // R8
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h60}, // R5
    '{3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h1F, 8'h1F}, // R10
    '{3'd0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h1F}, // R9
    '{3'd6, 8'h7F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0F}, // R2
    '{3'd5, 8'h90, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3F}, // R2
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF}, // R6
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h2A, 8'h2A}, // R7
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC5, 8'h45}, // R8
    '{3'd1, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h55}, // R1 R9
    '{3'd7, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h55}, // R9
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h15}, // R4
    '{3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h55}, // R4
    '{3'd3, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h45}, // R1
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h05}, // R4
    '{3'd0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h45}, // R4
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h7F}, // R8
    '{3'd4, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h30, 8'h30}, // R10
    '{3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hF0}  // R6
  };

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] alu_res_i;
  logic       half_cy_i;
  logic [2:0] op_class_i;
  logic       sw_sei_i, sw_cli_i, sw_clx_i, sw_setx_i;
  logic       int_enter_i, int_src_x_i, rti_load_i;
  logic [7:0] rti_val_i;
  logic [7:0] ccr_o;
  logic       i_mask_o, x_mask_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  ccr_unit u_ccr_unit (
    .clk_i, .rst_ni, .alu_res_i, .half_cy_i, .op_class_i,
    .sw_sei_i, .sw_cli_i, .sw_clx_i, .sw_setx_i,
    .int_enter_i, .int_src_x_i, .rti_load_i, .rti_val_i,
    .ccr_o, .i_mask_o, .x_mask_o
  );

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (ccr_o !== exp) begin
      errors++;
      $display("FAIL %s ccr actual %h expected %h", req, ccr_o, exp);
    end
    checks++;
    if (x_mask_o !== exp[7] || i_mask_o !== exp[6]) begin
      errors++;
      $display("FAIL R11 masks actual x=%b i=%b expected x=%b i=%b",
               x_mask_o, i_mask_o, exp[7], exp[6]);
    end
  endtask

  task automatic drive(input vec_t v);
    op_class_i  = v.op;  alu_res_i   = v.res; half_cy_i  = v.hc;
    sw_sei_i    = v.sei; sw_cli_i    = v.cli; sw_clx_i   = v.clx;
    sw_setx_i   = v.sxr; int_enter_i = v.ent; int_src_x_i = v.src;
    rti_load_i  = v.ld;  rti_val_i   = v.val;
  endtask

  task automatic idle();
    drive('0);
  endtask

  initial begin
    rst_ni = 1'b0;
    idle();
    repeat (3) @(negedge clk_i);
    check("R3 during reset", 8'hC0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R3 after release", 8'hC0);

    for (int k = 0; k < NV; k++) begin
      drive(TBL[k]);
      @(posedge clk_i);
      @(negedge clk_i);
      check($sformatf("R1-table vector %0d", k), TBL[k].exp);
    end
    idle();

    // R3: asynchronous reset in mid-run
    #1 rst_ni = 1'b0;
    #1 check("R3 async assert", 8'hC0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R3: commands inside the release window are ignored
    sw_cli_i = 1'b1; sw_clx_i = 1'b1; op_class_i = 3'd4; alu_res_i = 8'h80; half_cy_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R3 release window", 8'hC0);
    // R4 R8: first edge after release accepts commands
    @(negedge clk_i);
    check("R4 first active edge", 8'h30);
    idle();
    // R6 then R7 with X kept set by reload
    int_enter_i = 1'b1; int_src_x_i = 1'b1;
    @(negedge clk_i);
    check("R6 pin entry", 8'hF0);
    idle();
    rti_load_i = 1'b1; rti_val_i = 8'hFF;
    @(negedge clk_i);
    check("R7 reload keeps X", 8'hFF);
    idle();
    @(negedge clk_i);
    check("R9 idle hold", 8'hFF);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule